// File: doc/BRIEF.md
# Sleep Mode Entry/Exit Controller

This block sequences a synchronous memory into and out of a low-power sleep state. A sleep request arrives asynchronously and active high; it is first brought into the clock domain through a multi-flop synchroniser. The synchronised level then drives a four-state sequencer: awake, entering, asleep and exiting. Entry and exit each occupy a fixed number of clocks.

Only in the awake state does the block let accesses through, via an access-enable output to the access decoder. In every other state it holds the data outputs at high impedance. On the first cycle of entry it emits a one-cycle pulse, so that the rest of the memory drops any pending access as invalid. The block has no path into the storage array, so the stored contents are untouched across a sleep period.

While the memory recovers from sleep, the host must keep all chip enables and both address strobes inactive. If the block sees a strobe together with an active chip select during recovery, it suppresses that access and raises a sticky status flag. A request input left unconnected reads as inactive, because the pin has a pull-down.

Top module: `sleep_seq_ctrl`

## Requirements
- R1: While rst_n is low the block is awake: state_o is 0, acc_en is 1, and out_hiz, sleeping, abort_pend and recov_viol are 0; reset takes effect at once, without a clock edge.
- R2: A change of sleep_req is seen by the sequencer only after SYNC_STAGES rising edges (default 2). The state therefore leaves awake on the rising edge after the synchronised request goes high: the third edge after the request rises.
- R3: Entry holds state_o at 1 for exactly ENTRY_CYCLES cycles (default 2), then state_o goes to 2. The sleeping output is 1 exactly when state_o is 2.
- R4: When the synchronised request falls while asleep, the next edge moves state_o to 3. It stays there for exactly EXIT_CYCLES cycles (default 2), then returns to 0.
- R5: acc_en is 1 only when state_o is 0 (awake). Strobes applied while asleep or exiting neither start an access nor change the state.
- R6: out_hiz is 1 in every state other than awake, including the whole exit period.
- R7: abort_pend is high for exactly one cycle: the first cycle in which state_o is 1.
- R8: The first cycle after one in which state_o is 3, chip_sel is 1 and any strobe_n bit is 0, recov_viol goes to 1 and stays there. It clears when state_o next goes to 1. Strobes while chip_sel is 0, and strobes while asleep, leave it at 0.
- R9: A started sequence always runs to completion. A request that drops during entry still reaches asleep (2) and then exits. A request that rises during exit still reaches awake (0), and one cycle later entry begins (1).
- R10: The state_o encoding is 0 awake, 1 entering, 2 asleep, 3 exiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| chip_sel | input | 1 | High when all chip enables are active |
| strobe_n | input | NUM_STROBES | Address strobes, active low |
| acc_en | output | 1 | Access enable for the access decoder |
| out_hiz | output | 1 | Forces data outputs to high impedance |
| sleeping | output | 1 | Sleep status |
| abort_pend | output | 1 | One-cycle invalidate of any pending access |
| recov_viol | output | 1 | Sticky flag: access attempted during recovery |
| state_o | output | 2 | Sequencer state |

## Verification
The bench times every state change from the request edge through the synchroniser. A design that lost a synchroniser stage, or that miscounted entry or exit, would change state one cycle early or late and would fail the per-cycle state checks. It sends the request back the other way during entry and during exit; a design that aborted a sequence midway would skip the asleep or awake state. It also applies strobes during recovery with the chip select both high and low, and during sleep. A flag that is not sticky, is not cleared at the next entry, or ignores the chip select would show the wrong recov_viol value.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
   typedef enum logic [1:0] {
      ST_AWAKE = 2'd0,
      ST_ENTER = 2'd1,
      ST_SLEEP = 2'd2,
      ST_EXIT  = 2'd3
   } slp_state_t;
endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
   import sleep_seq_pkg::*;
#(
   parameter int ENTRY_CYCLES = 2,
   parameter int EXIT_CYCLES  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_s,
   output slp_state_t state_q,
   output logic       enter_go
);
   localparam int MAXC  = (ENTRY_CYCLES > EXIT_CYCLES) ? ENTRY_CYCLES : EXIT_CYCLES;
   localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
   localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYCLES - 1);
   localparam logic [CNT_W-1:0] EXIT_LOAD  = CNT_W'(EXIT_CYCLES - 1);

   slp_state_t       state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   assign enter_go = (state_q == ST_AWAKE) && req_s;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_AWAKE: begin
            if (req_s) begin
               state_d = ST_ENTER;
               cnt_d   = ENTRY_LOAD;
            end
         end
         ST_ENTER: begin
            if (cnt_q == '0) state_d = ST_SLEEP;
            else             cnt_d   = cnt_q - 1'b1;
         end
         ST_SLEEP: begin
            if (!req_s) begin
               state_d = ST_EXIT;
               cnt_d   = EXIT_LOAD;
            end
         end
         ST_EXIT: begin
            if (cnt_q == '0) state_d = ST_AWAKE;
            else             cnt_d   = cnt_q - 1'b1;
         end
         default: state_d = ST_AWAKE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_AWAKE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end
endmodule

// File: rtl/sleep_gate.sv
module sleep_gate
   import sleep_seq_pkg::*;
#(
   parameter int NUM_STROBES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  slp_state_t             state_q,
   input  logic                   enter_go,
   input  logic                   chip_sel,
   input  logic [NUM_STROBES-1:0] strobe_n,
   output logic                   acc_en,
   output logic                   out_hiz,
   output logic                   sleeping,
   output logic                   abort_pend,
   output logic                   recov_viol
);
   logic any_strobe;
   logic viol_hit;

   assign any_strobe = ~&strobe_n;
   assign viol_hit   = (state_q == ST_EXIT) && chip_sel && any_strobe;

   assign acc_en   = (state_q == ST_AWAKE);
   assign out_hiz  = (state_q != ST_AWAKE);
   assign sleeping = (state_q == ST_SLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         abort_pend <= 1'b0;
         recov_viol <= 1'b0;
      end else begin
         abort_pend <= enter_go;
         if (enter_go)      recov_viol <= 1'b0;
         else if (viol_hit) recov_viol <= 1'b1;
      end
   end
endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
   import sleep_seq_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int ENTRY_CYCLES = 2,
   parameter int EXIT_CYCLES  = 2,
   parameter int NUM_STROBES  = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sleep_req,
   input  logic                   chip_sel,
   input  logic [NUM_STROBES-1:0] strobe_n,
   output logic                   acc_en,
   output logic                   out_hiz,
   output logic                   sleeping,
   output logic                   abort_pend,
   output logic                   recov_viol,
   output logic [1:0]             state_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ENTRY_CYCLES < 1 || EXIT_CYCLES < 1) begin : g_bad_cnt
         $error("ENTRY_CYCLES and EXIT_CYCLES must be at least 1");
      end
      if (NUM_STROBES < 1) begin : g_bad_strobe
         $error("NUM_STROBES must be at least 1");
      end
   endgenerate

   logic       req_s;
   logic       enter_go;
   slp_state_t state_q;

   sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (sleep_req),
      .sync_out (req_s)
   );

   sleep_fsm #(
      .ENTRY_CYCLES (ENTRY_CYCLES),
      .EXIT_CYCLES  (EXIT_CYCLES)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_s    (req_s),
      .state_q  (state_q),
      .enter_go (enter_go)
   );

   sleep_gate #(.NUM_STROBES(NUM_STROBES)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .state_q    (state_q),
      .enter_go   (enter_go),
      .chip_sel   (chip_sel),
      .strobe_n   (strobe_n),
      .acc_en     (acc_en),
      .out_hiz    (out_hiz),
      .sleeping   (sleeping),
      .abort_pend (abort_pend),
      .recov_viol (recov_viol)
   );

   assign state_o = state_q;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       acc_en,
   input logic       out_hiz,
   input logic       sleeping,
   input logic       abort_pend,
   input logic       recov_viol,
   input logic [1:0] state_o
);
   assert_enable_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_en |-> (!out_hiz && !sleeping));

   assert_hiz_outside_awake_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != 2'd0) |-> out_hiz);

   assert_sleep_via_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sleeping) |-> ($past(state_o) == 2'd1));

   assert_awake_via_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_o == 2'd0) && ($past(state_o) != 2'd0)) |-> ($past(state_o) == 2'd3));

   assert_abort_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pend |=> !abort_pend);

   assert_abort_in_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pend |-> (state_o == 2'd1));

   assert_viol_from_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(recov_viol) |-> ($past(state_o) == 2'd3));
endmodule

bind sleep_seq_ctrl sleep_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_en     (acc_en),
   .out_hiz    (out_hiz),
   .sleeping   (sleeping),
   .abort_pend (abort_pend),
   .recov_viol (recov_viol),
   .state_o    (state_o)
);

// File: tb/sim_sleep_seq_ctrl.sv
`timescale 1ns/1ps
module sim_sleep_seq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0;
   logic       chip_sel = 1'b0;
   logic [1:0] strobe_n = 2'b11;
   logic       acc_en, out_hiz, sleeping, abort_pend, recov_viol;
   logic [1:0] state_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sleep_seq_ctrl #(
      .SYNC_STAGES(2), .ENTRY_CYCLES(2), .EXIT_CYCLES(2), .NUM_STROBES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .chip_sel(chip_sel),
      .strobe_n(strobe_n), .acc_en(acc_en), .out_hiz(out_hiz),
      .sleeping(sleeping), .abort_pend(abort_pend), .recov_viol(recov_viol),
      .state_o(state_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_state(string tag, int exp_st);
      chk({tag, " state"}, state_o, exp_st);
      chk({tag, " acc_en R5"}, acc_en, (exp_st == 0));
      chk({tag, " out_hiz R6"}, out_hiz, (exp_st != 0));
      chk({tag, " sleeping R3"}, sleeping, (exp_st == 2));
   endtask

   task automatic go_sleep();
      sleep_req = 1'b1;
      repeat (5) tick();
      chk_state("go_sleep R3", 2);
   endtask

   task automatic go_wake();
      sleep_req = 1'b0;
      repeat (5) tick();
      chk_state("go_wake R4", 0);
   endtask

   task automatic t_reset();
      #1;
      chk_state("reset R1", 0);
      chk("reset abort R1", abort_pend, 0);
      chk("reset viol R1", recov_viol, 0);
      tick();
      rst_n = 1'b1;
      tick();
      chk_state("after reset R1", 0);
   endtask

   task automatic t_entry();
      sleep_req = 1'b1;
      tick(); chk_state("entry e1 R2", 0);
      tick(); chk_state("entry e2 R2", 0);
      tick(); chk_state("entry e3 R3 R10", 1);
      chk("entry abort R7", abort_pend, 1);
      tick(); chk_state("entry e4 R3", 1);
      chk("entry abort off R7", abort_pend, 0);
      tick(); chk_state("entry e5 R3", 2);
      chk("asleep abort R7", abort_pend, 0);
   endtask

   task automatic t_exit();
      chip_sel = 1'b1; strobe_n = 2'b00;
      repeat (3) tick();
      chk_state("strobe asleep R5", 2);
      chk("strobe asleep viol R8", recov_viol, 0);
      chip_sel = 1'b0;
      sleep_req = 1'b0;
      tick(); chk_state("exit e1 R2", 2);
      tick(); chk_state("exit e2 R2", 2);
      tick(); chk_state("exit e3 R4", 3);
      tick(); chk_state("exit e4 R4", 3);
      tick(); chk_state("exit e5 R4", 0);
      chk("no-cs strobe viol R8", recov_viol, 0);
      strobe_n = 2'b11;
   endtask

   task automatic t_violation();
      go_sleep();
      sleep_req = 1'b0;
      repeat (3) tick();
      chk_state("viol exit R4", 3);
      chip_sel = 1'b1; strobe_n = 2'b01;
      tick();
      chk("viol set R8", recov_viol, 1);
      chk_state("viol suppressed R5", 3);
      chip_sel = 1'b0; strobe_n = 2'b11;
      tick();
      chk_state("viol awake R4", 0);
      repeat (3) tick();
      chk("viol sticky R8", recov_viol, 1);
      sleep_req = 1'b1;
      repeat (2) tick();
      chk("viol held pre-entry R8", recov_viol, 1);
      tick();
      chk_state("viol entry R3", 1);
      chk("viol cleared R8", recov_viol, 0);
      repeat (2) tick();
      chk_state("viol asleep R3", 2);
      go_wake();
   endtask

   task automatic t_late_drop();
      sleep_req = 1'b1;
      repeat (3) tick();
      chk_state("late drop entry R9", 1);
      sleep_req = 1'b0;
      tick(); chk_state("late drop e4 R9", 1);
      tick(); chk_state("late drop reaches sleep R9", 2);
      tick(); chk_state("late drop exit R9", 3);
      tick(); chk_state("late drop exit2 R9", 3);
      tick(); chk_state("late drop awake R9", 0);
   endtask

   task automatic t_reassert();
      go_sleep();
      sleep_req = 1'b0;
      repeat (3) tick();
      chk_state("reassert exit R9", 3);
      sleep_req = 1'b1;
      tick(); chk_state("reassert exit2 R9", 3);
      tick(); chk_state("reassert awake R9", 0);
      tick(); chk_state("reassert re-entry R9", 1);
      chk("reassert abort R7", abort_pend, 1);
      repeat (2) tick();
      chk_state("reassert asleep R9", 2);
   endtask

   task automatic t_async_reset();
      rst_n = 1'b0;
      #1;
      chk_state("async reset R1", 0);
      chk("async reset viol R1", recov_viol, 0);
      sleep_req = 1'b0;
      tick();
      rst_n = 1'b1;
      tick();
      chk_state("post async reset R1", 0);
   endtask

   initial begin
      t_reset();
      t_entry();
      t_exit();
      t_violation();
      t_late_drop();
      t_reassert();
      t_async_reset();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule